// File: doc/BRIEF.md
# Shared Bus Operation Concurrency Arbiter

This block sits between five kinds of bus operation and the single bus interface they share. The five kinds are processor single loads and stores, I/O and configuration cycles, general-purpose DMA (read or write), image-coprocessor DMA (write only), and target accesses started by external initiators. Each kind talks to the arbiter through a request, grant and done handshake. The arbiter decides which kinds may hold a grant at the same time. It keeps single-data-phase operations in issue order and stalls coprocessor write streams when a general-purpose DMA write needs the bus.

Single-data-phase operations are issued as one-cycle pulses. Each pulse carries a kind code and is queued in a small FIFO. Only the oldest entry is granted, so completions follow issue order. Processor accesses and I/O/configuration accesses can therefore never overlap.

The coprocessor stream tracks its byte offset inside a 64-byte block. While a general-purpose DMA write is pending or running, the stream finishes the current block and then pauses at the boundary. It continues once the write is done. General-purpose DMA reads never pause the stream.

Top module: `bus_op_arbiter`

## Requirements
- R1: After synchronous reset, all of the following are 0: every grant, `sp_full`, `cop_rej`, `busy` and `done_pulse`.
- R2: Single-phase operations are granted one at a time and strictly in issue order. `sp_kind` reports the kind of the granted entry: 0 processor, 1 I/O, 2 configuration. A queued entry is granted on the cycle after the grant is free. After `sp_done`, the grant is low for one cycle before the next entry is granted.
- R3: Processor and I/O/configuration activity (`busy[0]` and `busy[1]`) are never both 1.
- R4: The queue holds 4 entries, counting the granted head until it completes. `sp_full` is 1 while 4 entries are held. An issue pulse while full is dropped and never granted.
- R5: General-purpose DMA and external grants rise one cycle after the request and stay high until the cycle after done.
- R6: A coprocessor request with `cop_rd`=1 gives a one-cycle `cop_rej` on the next cycle and no grant.
- R7: A coprocessor stream starts only while `cop_en` is 1 and no general-purpose DMA write is pending or running. Otherwise the request is held off.
- R8: Each granted `cop_beat` advances the block offset by 4 bytes. When a general-purpose DMA write is pending, the coprocessor grant drops when the offset wraps to 0. A DMA write is granted only while the coprocessor grant is low.
- R9: A paused stream stays active (`busy[3]`=1) and gets its grant back the cycle after the DMA write grant falls.
- R10: A general-purpose DMA read and a coprocessor stream may both hold grants at once, and the read does not pause the stream.
- R11: `done_pulse[k]` is a one-cycle pulse, on the cycle after a done input while class k holds its grant. Class order is processor, I/O/configuration, general DMA, coprocessor, external.
- R12: External, general DMA read, coprocessor and one single-phase class can all be busy at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cop_en | input | 1 | Software enable for coprocessor streams |
| sp_issue | input | 1 | One-cycle issue of a single-phase operation |
| sp_kind_in | input | 2 | Kind of issued operation (0 cpu, 1 I/O, 2 config) |
| sp_done | input | 1 | Granted single-phase operation finished |
| sp_gnt | output | 1 | Single-phase grant |
| sp_kind | output | 2 | Kind of the granted single-phase operation |
| sp_full | output | 1 | Single-phase queue full |
| gdma_req | input | 1 | General DMA request |
| gdma_wr | input | 1 | General DMA direction, 1 = write |
| gdma_done | input | 1 | General DMA finished |
| gdma_gnt | output | 1 | General DMA grant |
| cop_req | input | 1 | Coprocessor stream request |
| cop_rd | input | 1 | Coprocessor request is a read (rejected) |
| cop_beat | input | 1 | Coprocessor 32-bit data beat |
| cop_done | input | 1 | Coprocessor stream finished |
| cop_gnt | output | 1 | Coprocessor grant |
| cop_rej | output | 1 | Coprocessor read rejected |
| ext_req | input | 1 | External initiator access request |
| ext_done | input | 1 | External access finished |
| ext_gnt | output | 1 | External grant |
| busy | output | 5 | Per-class activity |
| done_pulse | output | 5 | Per-class completion pulses |

## Verification
The assertions check on every cycle the rules that hold in any state:
- no processor/I/O overlap;
- a DMA write grant never coexists with a coprocessor grant;
- a coprocessor grant only drops mid-stream at offset 0;
- a stream only starts with the enable set;
- rejections and done pulses are caused by the right inputs;
- grants hold until done.

Issue-order granting, dropping an issue into a full queue, the exact count of beats until the pause, resumption after the write, and full four-class concurrency depend on sequences of stimulus. Only the bench's scenarios, compared each clock against the behavioural model, can show them.

// File: rtl/bop_pkg.sv
package bop_pkg;
  typedef enum logic [1:0] {
    SP_CPU = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2
  } sp_kind_e;

  localparam int NCLASS = 5;
endpackage

// File: rtl/bop_sp_order.sv
module bop_sp_order #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [1:0] kind_in,
  input  logic       done,
  output logic       gnt,
  output logic [1:0] kind,
  output logic       full,
  output logic       busy_cpu,
  output logic       busy_iocfg,
  output logic       dp_cpu,
  output logic       dp_iocfg
);
  import bop_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count, count_n;
  logic          push, pop;

  assign push    = issue && (count != CW'(DEPTH));
  assign pop     = gnt && done;
  assign count_n = count + CW'(push) - CW'(pop);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= kind_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      gnt      <= 1'b0;
      kind     <= SP_CPU;
      full     <= 1'b0;
      dp_cpu   <= 1'b0;
      dp_iocfg <= 1'b0;
    end else begin
      count    <= count_n;
      full     <= (count_n == CW'(DEPTH));
      dp_cpu   <= pop && (kind == SP_CPU);
      dp_iocfg <= pop && (kind != SP_CPU);
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) begin
        rp  <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        gnt <= 1'b0;
      end else if (!gnt && count != '0) begin
        gnt  <= 1'b1;
        kind <= mem[rp];
      end
    end
  end

  assign busy_cpu   = gnt && (kind == SP_CPU);
  assign busy_iocfg = gnt && (kind != SP_CPU);
endmodule

// File: rtl/bop_chan.sv
module bop_chan (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic block,
  input  logic done,
  output logic gnt,
  output logic dp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt <= 1'b0;
      dp  <= 1'b0;
    end else begin
      dp <= 1'b0;
      if (gnt && done) begin
        gnt <= 1'b0;
        dp  <= 1'b1;
      end else if (!gnt && req && !block) begin
        gnt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bop_cop_ctrl.sv
module bop_cop_ctrl #(
  parameter int BLOCK_BYTES = 64,
  parameter int BEAT_BYTES  = 4,
  localparam int OW = $clog2(BLOCK_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          req,
  input  logic          rd,
  input  logic          beat,
  input  logic          done,
  input  logic          wr_hold,
  output logic          gnt,
  output logic          act,
  output logic          rej,
  output logic          dp,
  output logic [OW-1:0] off
);
  localparam logic [OW-1:0] STEP = OW'(BEAT_BYTES);
  logic [OW-1:0] off_n;

  assign off_n = (gnt && beat) ? off + STEP : off;

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt <= 1'b0;
      act <= 1'b0;
      rej <= 1'b0;
      dp  <= 1'b0;
      off <= '0;
    end else begin
      rej <= req && rd && !act;
      dp  <= 1'b0;
      if (act && gnt && done) begin
        act <= 1'b0;
        gnt <= 1'b0;
        off <= '0;
        dp  <= 1'b1;
      end else if (act) begin
        off <= off_n;
        gnt <= !(wr_hold && off_n == '0);
      end else if (req && !rd && en && !wr_hold) begin
        act <= 1'b1;
        gnt <= 1'b1;
        off <= '0;
      end
    end
  end
endmodule

// File: rtl/bus_op_arbiter.sv
module bus_op_arbiter #(
  parameter int SP_DEPTH    = 4,
  parameter int BLOCK_BYTES = 64,
  parameter int BEAT_BYTES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cop_en,
  input  logic       sp_issue,
  input  logic [1:0] sp_kind_in,
  input  logic       sp_done,
  output logic       sp_gnt,
  output logic [1:0] sp_kind,
  output logic       sp_full,
  input  logic       gdma_req,
  input  logic       gdma_wr,
  input  logic       gdma_done,
  output logic       gdma_gnt,
  input  logic       cop_req,
  input  logic       cop_rd,
  input  logic       cop_beat,
  input  logic       cop_done,
  output logic       cop_gnt,
  output logic       cop_rej,
  input  logic       ext_req,
  input  logic       ext_done,
  output logic       ext_gnt,
  output logic [4:0] busy,
  output logic [4:0] done_pulse
);
  localparam int OW = $clog2(BLOCK_BYTES);

  logic          busy_cpu, busy_iocfg, dp_cpu, dp_iocfg;
  logic          gdma_dp, cop_dp, ext_dp, cop_act;
  logic          gdma_is_wr, wr_hold, gdma_block;
  logic [OW-1:0] cop_off;

  assign wr_hold    = (gdma_req && gdma_wr && !gdma_gnt) || (gdma_gnt && gdma_is_wr);
  assign gdma_block = gdma_wr && cop_gnt;

  always_ff @(posedge clk) begin
    if (rst) gdma_is_wr <= 1'b0;
    else if (!gdma_gnt && gdma_req && !gdma_block) gdma_is_wr <= gdma_wr;
  end

  bop_sp_order #(.DEPTH(SP_DEPTH)) u_sp (
    .clk(clk), .rst(rst), .issue(sp_issue), .kind_in(sp_kind_in),
    .done(sp_done), .gnt(sp_gnt), .kind(sp_kind), .full(sp_full),
    .busy_cpu(busy_cpu), .busy_iocfg(busy_iocfg),
    .dp_cpu(dp_cpu), .dp_iocfg(dp_iocfg)
  );

  bop_chan u_gdma (
    .clk(clk), .rst(rst), .req(gdma_req), .block(gdma_block),
    .done(gdma_done), .gnt(gdma_gnt), .dp(gdma_dp)
  );

  bop_chan u_ext (
    .clk(clk), .rst(rst), .req(ext_req), .block(1'b0),
    .done(ext_done), .gnt(ext_gnt), .dp(ext_dp)
  );

  bop_cop_ctrl #(.BLOCK_BYTES(BLOCK_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_cop (
    .clk(clk), .rst(rst), .en(cop_en), .req(cop_req), .rd(cop_rd),
    .beat(cop_beat), .done(cop_done), .wr_hold(wr_hold),
    .gnt(cop_gnt), .act(cop_act), .rej(cop_rej), .dp(cop_dp), .off(cop_off)
  );

  assign busy       = {ext_gnt, cop_act, gdma_gnt, busy_iocfg, busy_cpu};
  assign done_pulse = {ext_dp, cop_dp, gdma_dp, dp_iocfg, dp_cpu};
endmodule

// File: rtl/bus_op_arbiter_chk.sv
module bus_op_arbiter_chk #(
  parameter int OW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          cop_en,
  input logic          cop_req,
  input logic          cop_rd,
  input logic          cop_gnt,
  input logic          cop_rej,
  input logic          gdma_gnt,
  input logic          gdma_done,
  input logic          gdma_is_wr,
  input logic          ext_gnt,
  input logic          ext_done,
  input logic [4:0]    busy,
  input logic [4:0]    done_pulse,
  input logic [OW-1:0] cop_off
);
  // R3
  sp_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy[0] && busy[1]));
  // R5
  gdma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gdma_gnt && !gdma_done) |=> gdma_gnt);
  // R6
  rej_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cop_rej |-> $past(cop_req && cop_rd));
  // R7
  cop_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy[3]) |-> $past(cop_en));
  // R8
  wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(gdma_gnt && gdma_is_wr && cop_gnt));
  // R8
  pause_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cop_gnt) && busy[3]) |-> (cop_off == '0));
  // R11
  ext_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse[4] |-> $past(ext_gnt && ext_done));
  // R11
  gdma_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse[2] |-> $past(gdma_gnt && gdma_done));
endmodule

bind bus_op_arbiter bus_op_arbiter_chk #(.OW($clog2(BLOCK_BYTES))) u_chk (
  .clk(clk), .rst(rst), .cop_en(cop_en), .cop_req(cop_req), .cop_rd(cop_rd),
  .cop_gnt(cop_gnt), .cop_rej(cop_rej), .gdma_gnt(gdma_gnt),
  .gdma_done(gdma_done), .gdma_is_wr(gdma_is_wr), .ext_gnt(ext_gnt),
  .ext_done(ext_done), .busy(busy), .done_pulse(done_pulse), .cop_off(cop_off)
);

// File: tb/bus_op_arbiter_tb.sv
module bus_op_arbiter_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cop_en = 0, sp_issue = 0, sp_done = 0;
  logic [1:0] sp_kind_in = 0;
  logic gdma_req = 0, gdma_wr = 0, gdma_done = 0;
  logic cop_req = 0, cop_rd = 0, cop_beat = 0, cop_done = 0;
  logic ext_req = 0, ext_done = 0;
  logic sp_gnt, sp_full, gdma_gnt, cop_gnt, cop_rej, ext_gnt;
  logic [1:0] sp_kind;
  logic [4:0] busy, done_pulse;

  int nchecks = 0, nerr = 0, cycles = 0;

  always #5 clk = ~clk;

  bus_op_arbiter u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int q[$];
  bit m_sp_gnt, m_full, m_gdma_gnt, m_gdma_wr, m_cop_gnt, m_cop_act, m_rej, m_ext_gnt;
  int m_kind, m_off;
  bit [4:0] m_dp;

  always @(posedge clk) begin : model
    int sz;
    bit push, hold, blk, o_gdma, o_cop;
    int noff;
    if (rst) begin
      q.delete();
      m_sp_gnt = 0; m_full = 0; m_gdma_gnt = 0; m_gdma_wr = 0;
      m_cop_gnt = 0; m_cop_act = 0; m_rej = 0; m_ext_gnt = 0;
      m_kind = 0; m_off = 0; m_dp = 0;
    end else begin
      m_dp = 0;
      o_gdma = m_gdma_gnt; o_cop = m_cop_gnt;
      hold = (gdma_req && gdma_wr && !o_gdma) || (o_gdma && m_gdma_wr);
      blk = gdma_wr && o_cop;
      sz = q.size();
      push = sp_issue && sz < 4;
      if (m_sp_gnt && sp_done) begin
        m_dp[(m_kind == 0) ? 0 : 1] = 1;
        void'(q.pop_front());
        m_sp_gnt = 0;
      end else if (!m_sp_gnt && sz > 0) begin
        m_sp_gnt = 1; m_kind = q[0];
      end
      if (push) q.push_back(int'(sp_kind_in));
      m_full = (q.size() == 4);
      if (o_gdma && gdma_done) begin m_gdma_gnt = 0; m_dp[2] = 1; end
      else if (!o_gdma && gdma_req && !blk) begin m_gdma_gnt = 1; m_gdma_wr = gdma_wr; end
      m_rej = cop_req && cop_rd && !m_cop_act;
      if (m_cop_act && o_cop && cop_done) begin
        m_cop_act = 0; m_cop_gnt = 0; m_off = 0; m_dp[3] = 1;
      end else if (m_cop_act) begin
        noff = (o_cop && cop_beat) ? (m_off + 4) % 64 : m_off;
        m_off = noff;
        m_cop_gnt = !(hold && noff == 0);
      end else if (cop_req && !cop_rd && cop_en && !hold) begin
        m_cop_act = 1; m_cop_gnt = 1; m_off = 0;
      end
      if (m_ext_gnt && ext_done) begin m_ext_gnt = 0; m_dp[4] = 1; end
      else if (!m_ext_gnt && ext_req) m_ext_gnt = 1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(sp_gnt == m_sp_gnt, "R2 sp_gnt", sp_gnt, m_sp_gnt);
      if (m_sp_gnt) chk(int'(sp_kind) == m_kind, "R2 sp_kind", sp_kind, m_kind);
      chk(sp_full == m_full, "R4 sp_full", sp_full, m_full);
      chk(gdma_gnt == m_gdma_gnt, "R5 gdma_gnt", gdma_gnt, m_gdma_gnt);
      chk(ext_gnt == m_ext_gnt, "R5 ext_gnt", ext_gnt, m_ext_gnt);
      chk(cop_gnt == m_cop_gnt, "R8 cop_gnt", cop_gnt, m_cop_gnt);
      chk(cop_rej == m_rej, "R6 cop_rej", cop_rej, m_rej);
      chk(done_pulse == m_dp, "R11 done_pulse", done_pulse, m_dp);
      chk(busy == {m_ext_gnt, m_cop_act, m_gdma_gnt, m_sp_gnt && m_kind != 0,
                   m_sp_gnt && m_kind == 0}, "R11 busy", busy, 0);
      chk(!(busy[0] && busy[1]), "R3 overlap", busy[1:0], 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nerr++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int kinds[4];
    int n;
    cyc(3);
    rst = 0;
    // R1
    chk(busy == 0 && done_pulse == 0 && !sp_gnt && !gdma_gnt && !cop_gnt
        && !ext_gnt && !sp_full && !cop_rej, "R1 reset", busy, 0);
    cyc(1);
    // R2 / R4: fill the queue, then overflow
    sp_issue = 1;
    sp_kind_in = 0; cyc(1);
    sp_kind_in = 1; cyc(1);
    sp_kind_in = 2; cyc(1);
    sp_kind_in = 0; cyc(1);
    chk(sp_full == 1, "R4 full", sp_full, 1);
    sp_kind_in = 1; cyc(1);
    sp_issue = 0;
    for (int i = 0; i < 4; i++) begin
      n = 0;
      while (!sp_gnt && n < 20) begin cyc(1); n++; end
      kinds[i] = sp_kind;
      sp_done = 1; cyc(1); sp_done = 0;
    end
    chk(kinds[0] == 0 && kinds[1] == 1 && kinds[2] == 2 && kinds[3] == 0,
        "R2 order", kinds[2], 2);
    cyc(4);
    chk(sp_gnt == 0, "R4 dropped issue", sp_gnt, 0);
    // R6
    cop_req = 1; cop_rd = 1; cyc(1);
    chk(cop_rej == 1, "R6 reject", cop_rej, 1);
    cop_req = 0; cop_rd = 0; cyc(1);
    chk(cop_gnt == 0 && cop_rej == 0, "R6 no grant", cop_gnt, 0);
    // R7
    cop_req = 1; cyc(3);
    chk(cop_gnt == 0, "R7 enable off", cop_gnt, 0);
    cop_en = 1; cyc(2);
    chk(cop_gnt == 1, "R7 enable on", cop_gnt, 1);
    cop_req = 0;
    // R8
    cop_beat = 1; cyc(3);
    gdma_req = 1; gdma_wr = 1;
    n = 0;
    while (cop_gnt && n < 40) begin cyc(1); n++; end
    chk(n == 13, "R8 beats to boundary", n, 13);
    cop_beat = 0; cyc(1);
    chk(gdma_gnt == 1 && cop_gnt == 0 && busy[3] == 1, "R8 write granted", gdma_gnt, 1);
    // R9
    gdma_done = 1; gdma_req = 0; cyc(1);
    gdma_done = 0; gdma_wr = 0;
    chk(done_pulse[2] == 1, "R11 gdma pulse", done_pulse[2], 1);
    cyc(1);
    chk(cop_gnt == 1 && gdma_gnt == 0, "R9 resume", cop_gnt, 1);
    // R10, R12
    gdma_req = 1; cop_beat = 1; cyc(2);
    chk(gdma_gnt == 1 && cop_gnt == 1, "R10 read with stream", gdma_gnt, 1);
    ext_req = 1; sp_issue = 1; sp_kind_in = 2; cyc(1);
    sp_issue = 0; cyc(2);
    chk(busy == 5'b11110 && cop_gnt == 1, "R12 concurrency", busy, 5'b11110);
    cop_beat = 0;
    // R11
    cop_done = 1; cyc(1); cop_done = 0;
    chk(done_pulse[3] == 1, "R11 cop pulse", done_pulse[3], 1);
    cyc(1);
    chk(done_pulse[3] == 0, "R11 single pulse", done_pulse[3], 0);
    ext_done = 1; ext_req = 0; cyc(1); ext_done = 0;
    chk(done_pulse[4] == 1, "R11 ext pulse", done_pulse[4], 1);
    gdma_done = 1; gdma_req = 0; sp_done = 1; cyc(1);
    gdma_done = 0; sp_done = 0;
    chk(done_pulse[1] == 1, "R11 iocfg pulse", done_pulse[1], 1);
    cyc(3);
    chk(busy == 0, "R11 all idle", busy, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule